// File: doc/BRIEF.md
# Field 3:2 Pulldown Cadence Detector

This block watches interlaced video one field at a time and decides whether the material carries a 3:2 pulldown pattern. An upstream comparator presents one difference score per line, comparing the line with the same line of the previous field. The detector first conditions each score by shifting it right to suppress noise. It then compares the result with a threshold and counts the lines in the field that differ. When the field-end strobe arrives, it marks the field as a repeat or as new.

A five-position phase counter follows where the single repeat field of each five-field group is expected. A saturating agreement counter, with separate lock and unlock thresholds, decides when reverse telecine may be applied. Downstream weaving logic reads the lock flag and the phase. Tuning software reads the differing-line count of the most recent field. All thresholds arrive on configuration inputs.

Top module: `cad32_detector`

## Requirements
- R1: Each valid line score is shifted right by `cfg_noise_shift` bits before any comparison, so with a shift of 5 a score of 511 conditions to 15 and a score of 512 conditions to 16.
- R2: A valid line counts as differing when its conditioned score is greater than or equal to `cfg_diff_thr`. A line presented with `line_valid` low is neither counted as a line nor as a differing line.
- R3: One cycle after `field_end` is high, `diff_count` shows the number of differing lines of the field just closed, including a line presented in the same cycle as the strobe. It holds that value until the next field end.
- R4: A closed field is a repeat when its differing-line count is strictly below its total line count shifted right by `cfg_line_ratio`. With 40 lines and ratio 4, 1 differing line is a repeat and 2 are not.
- R5: `cadence_phase` takes values 0 to 4 and gives the position of the next field to close, where 0 is the slot expected to hold the repeat. It changes only one cycle after a field end.
- R6: At each field end an agreement counter increments when the field's repeat status matches the expectation of its phase, and decrements otherwise. While unlocked, `cadence_locked` rises when the updated counter is at least `cfg_lock_thr`. With the default threshold of 6 and a clean cadence from reset, lock comes on the sixth field and not the fifth.
- R7: While locked, `cadence_locked` falls when the updated counter is at or below `cfg_unlock_thr` (default 4). After unlocking, the block stays unlocked until the counter again reaches the lock threshold.
- R8: While unlocked, a repeat field sets the next phase to 1 (re-alignment). While locked, the phase always steps by one, modulo 5, regardless of the field.
- R9: The agreement counter saturates at 15 and at 0. After 20 agreeing fields it takes exactly 11 disagreeing fields to unlock with an unlock threshold of 4.
- R10: A synchronous active-high `rst` clears the line counters, `diff_count`, the agreement counter, `cadence_locked` and `cadence_phase`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| line_valid | input | 1 | A line score is present this cycle |
| line_score | input | 16 | Raw difference score of the line |
| field_end | input | 1 | One-cycle strobe closing the current field |
| cfg_noise_shift | input | 4 | Right shift applied to each score |
| cfg_diff_thr | input | 8 | Conditioned score at or above which a line differs |
| cfg_line_ratio | input | 4 | Shift applied to the line count to form the repeat limit |
| cfg_lock_thr | input | 4 | Agreement count needed to gain lock |
| cfg_unlock_thr | input | 4 | Agreement count at or below which lock is lost |
| diff_count | output | 12 | Differing lines of the most recently closed field |
| cadence_locked | output | 1 | Reverse telecine may be applied |
| cadence_phase | output | 3 | Position (0..4) of the next field; 0 expects the repeat |

## Verification
The checker holds on every cycle that the phase stays in 0..4, and that the phase, the lock flag and the published count change only on the cycle after a field strobe. It also checks that a locked detector steps its phase by exactly one, that an unlocked detector either steps or re-aligns to 1, and that reset leaves a clean state. Only the bench scenarios can show the numeric behaviour: the shift-then-compare boundary on line scores, the strict repeat limit formed from the line count, the sixth-field lock instant, the saturation at 15 seen as eleven disagreements before unlock, and the hysteresis gap that keeps an unlocked detector off at count 5.

// File: rtl/cad32_pkg.sv
package cad32_pkg;
    // A 3:2 pulldown group spans five fields with exactly one repeat.
    localparam int unsigned CAD_PERIOD = 5;
    localparam int unsigned PHASE_W    = 3;
    typedef logic [PHASE_W-1:0] phase_t;
    localparam phase_t PHASE_REPEAT = phase_t'(0);
    localparam phase_t PHASE_LAST   = phase_t'(CAD_PERIOD - 1);
endpackage

// File: rtl/cad32_line_cond.sv
module cad32_line_cond #(
    parameter int unsigned SCORE_W = 16,
    parameter int unsigned THR_W   = 8,
    parameter int unsigned SHIFT_W = 4
) (
    input  logic               line_valid,
    input  logic [SCORE_W-1:0] line_score,
    input  logic [SHIFT_W-1:0] noise_shift,
    input  logic [THR_W-1:0]   diff_thr,
    output logic               line_differs
);
    localparam int unsigned CMP_W = (SCORE_W > THR_W) ? SCORE_W : THR_W;

    logic [SCORE_W-1:0] cond_score;
    logic [CMP_W-1:0]   cmp_score;
    logic [CMP_W-1:0]   cmp_thr;

    always_comb begin
        cond_score   = line_score >> noise_shift;
        cmp_score    = CMP_W'(cond_score);
        cmp_thr      = CMP_W'(diff_thr);
        line_differs = line_valid && (cmp_score >= cmp_thr);
    end
endmodule

// File: rtl/cad32_field_acc.sv
module cad32_field_acc #(
    parameter int unsigned LINE_W  = 12,
    parameter int unsigned RATIO_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               line_valid,
    input  logic               line_differs,
    input  logic               field_end,
    input  logic [RATIO_W-1:0] line_ratio,
    output logic               field_is_repeat,
    output logic [LINE_W-1:0]  diff_count
);
    localparam logic [LINE_W-1:0] LINE_MAX = '1;
    localparam logic [LINE_W-1:0] LINE_ONE = LINE_W'(1);

    typedef struct packed {
        logic [LINE_W-1:0] lines;
        logic [LINE_W-1:0] diffs;
        logic [LINE_W-1:0] published;
    } acc_state_t;

    acc_state_t state_d, state_q;
    logic [LINE_W-1:0] lines_total;
    logic [LINE_W-1:0] diffs_total;
    logic [LINE_W-1:0] repeat_limit;

    always_comb begin
        state_d     = state_q;
        lines_total = state_q.lines;
        diffs_total = state_q.diffs;
        if (line_valid && state_q.lines != LINE_MAX) begin
            lines_total = state_q.lines + LINE_ONE;
        end
        if (line_differs && state_q.diffs != LINE_MAX) begin
            diffs_total = state_q.diffs + LINE_ONE;
        end
        repeat_limit    = lines_total >> line_ratio;
        field_is_repeat = diffs_total < repeat_limit;
        if (field_end) begin
            state_d.lines     = '0;
            state_d.diffs     = '0;
            state_d.published = diffs_total;
        end else begin
            state_d.lines = lines_total;
            state_d.diffs = diffs_total;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign diff_count = state_q.published;
endmodule

// File: rtl/cad32_tracker.sv
module cad32_tracker
    import cad32_pkg::*;
#(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             field_end,
    input  logic             field_is_repeat,
    input  logic [CNT_W-1:0] lock_thr,
    input  logic [CNT_W-1:0] unlock_thr,
    output logic             locked,
    output phase_t           phase
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam phase_t           PH_ONE  = phase_t'(1);

    typedef struct packed {
        logic [CNT_W-1:0] agree_cnt;
        phase_t           phase;
        logic             locked;
    } trk_state_t;

    trk_state_t state_d, state_q;
    logic             expect_repeat;
    logic             agrees;
    logic [CNT_W-1:0] cnt_next;
    phase_t           phase_step;

    always_comb begin
        state_d       = state_q;
        expect_repeat = (state_q.phase == PHASE_REPEAT);
        agrees        = (field_is_repeat == expect_repeat);
        if (agrees) begin
            cnt_next = (state_q.agree_cnt == CNT_MAX) ? state_q.agree_cnt
                                                      : state_q.agree_cnt + CNT_ONE;
        end else begin
            cnt_next = (state_q.agree_cnt == '0) ? state_q.agree_cnt
                                                 : state_q.agree_cnt - CNT_ONE;
        end
        phase_step = (state_q.phase == PHASE_LAST) ? PHASE_REPEAT : state_q.phase + PH_ONE;
        if (field_end) begin
            state_d.agree_cnt = cnt_next;
            if (!state_q.locked && field_is_repeat) begin
                state_d.phase = PH_ONE;
            end else begin
                state_d.phase = phase_step;
            end
            if (!state_q.locked) begin
                state_d.locked = (cnt_next >= lock_thr);
            end else begin
                state_d.locked = (cnt_next > unlock_thr);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign locked = state_q.locked;
    assign phase  = state_q.phase;
endmodule

// File: rtl/cad32_detector.sv
module cad32_detector #(
    parameter int unsigned SCORE_W = 16,
    parameter int unsigned THR_W   = 8,
    parameter int unsigned SHIFT_W = 4,
    parameter int unsigned LINE_W  = 12,
    parameter int unsigned RATIO_W = 4,
    parameter int unsigned CNT_W   = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               line_valid,
    input  logic [SCORE_W-1:0] line_score,
    input  logic               field_end,
    input  logic [SHIFT_W-1:0] cfg_noise_shift,
    input  logic [THR_W-1:0]   cfg_diff_thr,
    input  logic [RATIO_W-1:0] cfg_line_ratio,
    input  logic [CNT_W-1:0]   cfg_lock_thr,
    input  logic [CNT_W-1:0]   cfg_unlock_thr,
    output logic [LINE_W-1:0]  diff_count,
    output logic               cadence_locked,
    output logic [2:0]         cadence_phase
);
    logic line_differs;
    logic field_is_repeat;

    cad32_line_cond #(
        .SCORE_W(SCORE_W), .THR_W(THR_W), .SHIFT_W(SHIFT_W)
    ) u_cond (
        .line_valid  (line_valid),
        .line_score  (line_score),
        .noise_shift (cfg_noise_shift),
        .diff_thr    (cfg_diff_thr),
        .line_differs(line_differs)
    );

    cad32_field_acc #(
        .LINE_W(LINE_W), .RATIO_W(RATIO_W)
    ) u_acc (
        .clk            (clk),
        .rst            (rst),
        .line_valid     (line_valid),
        .line_differs   (line_differs),
        .field_end      (field_end),
        .line_ratio     (cfg_line_ratio),
        .field_is_repeat(field_is_repeat),
        .diff_count     (diff_count)
    );

    cad32_tracker #(
        .CNT_W(CNT_W)
    ) u_trk (
        .clk            (clk),
        .rst            (rst),
        .field_end      (field_end),
        .field_is_repeat(field_is_repeat),
        .lock_thr       (cfg_lock_thr),
        .unlock_thr     (cfg_unlock_thr),
        .locked         (cadence_locked),
        .phase          (cadence_phase)
    );
endmodule

// File: rtl/cad32_checker.sv
module cad32_checker #(
    parameter int unsigned LINE_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              field_end,
    input logic [LINE_W-1:0] diff_count,
    input logic              cadence_locked,
    input logic [2:0]        cadence_phase
);
    function automatic logic [2:0] step_of(input logic [2:0] p);
        return (p == 3'd4) ? 3'd0 : p + 3'd1;
    endfunction

    assert_phase_range_R5: assert property (@(posedge clk) disable iff (rst)
        cadence_phase <= 3'd4);

    assert_phase_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(field_end)) |-> $stable(cadence_phase));

    assert_lock_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(field_end)) |-> $stable(cadence_locked));

    assert_count_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(field_end)) |-> $stable(diff_count));

    assert_locked_step_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(field_end) && $past(cadence_locked))
        |-> cadence_phase == step_of($past(cadence_phase)));

    assert_unlocked_align_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(field_end) && !$past(cadence_locked))
        |-> (cadence_phase == 3'd1 || cadence_phase == step_of($past(cadence_phase))));

    assert_reset_clear_R10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cadence_phase == 3'd0 && !cadence_locked && diff_count == '0));
endmodule

bind cad32_detector cad32_checker #(.LINE_W(LINE_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .field_end     (field_end),
    .diff_count    (diff_count),
    .cadence_locked(cadence_locked),
    .cadence_phase (cadence_phase)
);

// File: tb/sim_cad32_detector.sv
module sim_cad32_detector;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        line_valid = 1'b0;
    logic [15:0] line_score = '0;
    logic        field_end = 1'b0;
    logic [3:0]  cfg_noise_shift = 4'd5;
    logic [7:0]  cfg_diff_thr = 8'd16;
    logic [3:0]  cfg_line_ratio = 4'd4;
    logic [3:0]  cfg_lock_thr = 4'd6;
    logic [3:0]  cfg_unlock_thr = 4'd4;
    logic [11:0] diff_count;
    logic        cadence_locked;
    logic [2:0]  cadence_phase;

    int checks = 0;
    int errors = 0;
    int m_cnt = 0;
    int m_phase = 0;
    bit m_lock = 1'b0;

    always #4 clk = ~clk;

    cad32_detector u0 (
        .clk(clk), .rst(rst), .line_valid(line_valid), .line_score(line_score),
        .field_end(field_end), .cfg_noise_shift(cfg_noise_shift),
        .cfg_diff_thr(cfg_diff_thr), .cfg_line_ratio(cfg_line_ratio),
        .cfg_lock_thr(cfg_lock_thr), .cfg_unlock_thr(cfg_unlock_thr),
        .diff_count(diff_count), .cadence_locked(cadence_locked),
        .cadence_phase(cadence_phase)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic put(input bit v, input int score, input bit fe);
        @(negedge clk);
        line_valid = v;
        line_score = 16'(score);
        field_end  = fe;
    endtask

    task automatic close_field();
        put(0, 0, 1);
        put(0, 0, 0);
    endtask

    // Reference expectation from R5..R9: agreement count, phase, lock.
    task automatic model_field(input bit rep);
        bit agree;
        agree = (rep == (m_phase == 0));
        if (agree) m_cnt = (m_cnt == 15) ? 15 : m_cnt + 1;
        else       m_cnt = (m_cnt == 0) ? 0 : m_cnt - 1;
        if (!m_lock && rep) m_phase = 1;
        else                m_phase = (m_phase == 4) ? 0 : m_phase + 1;
        if (!m_lock) m_lock = (m_cnt >= int'(cfg_lock_thr));
        else         m_lock = (m_cnt > int'(cfg_unlock_thr));
    endtask

    task automatic expect_state(input string req);
        chk({req, " phase"}, int'(cadence_phase), m_phase);
        chk({req, " locked"}, int'(cadence_locked), int'(m_lock));
    endtask

    // Field of nl lines, the first nd carrying a clearly differing score.
    task automatic send_field(input int nl, input int nd, input string req);
        for (int i = 0; i < nl; i++) put(1, (i < nd) ? 4000 : 0, 0);
        close_field();
        model_field(nd < (nl >> cfg_line_ratio));
        chk({req, " diff_count"}, int'(diff_count), nd);
        expect_state(req);
    endtask

    task automatic cad_field(input bit rep, input string req);
        send_field(40, rep ? 0 : 40, req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; line_valid = 0; field_end = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_cnt = 0; m_phase = 0; m_lock = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        chk("R10 diff_count after reset", int'(diff_count), 0);
        chk("R10 locked after reset", int'(cadence_locked), 0);
        chk("R10 phase after reset", int'(cadence_phase), 0);
    endtask

    task automatic t_noise();
        put(1, 511, 0); put(1, 512, 0); put(1, 1023, 0); put(0, 0, 0);
        close_field(); model_field(1'b0);
        chk("R1 R2 shift5 thr16 count", int'(diff_count), 2);
        expect_state("R1");
        cfg_noise_shift = 4'd4; cfg_diff_thr = 8'd20;
        put(1, 319, 0); put(1, 320, 0); put(1, 5000, 0); put(1, 0, 0);
        close_field(); model_field(1'b0);
        chk("R1 R2 shift4 thr20 count", int'(diff_count), 2);
        put(1, 4000, 0); put(0, 9000, 0); put(1, 4000, 0);
        close_field(); model_field(1'b0);
        chk("R2 invalid line ignored", int'(diff_count), 2);
        cfg_noise_shift = 4'd5; cfg_diff_thr = 8'd16;
    endtask

    task automatic t_strobe();
        put(1, 0, 0); put(1, 0, 0); put(1, 0, 0); put(1, 4000, 1); put(0, 0, 0);
        model_field(1'b0);
        chk("R3 line on strobe counted", int'(diff_count), 1);
        put(1, 4000, 0); put(1, 4000, 0); put(0, 0, 0);
        chk("R3 count held mid field", int'(diff_count), 1);
        close_field(); model_field(1'b0);
        chk("R3 next field count", int'(diff_count), 2);
        expect_state("R3");
    endtask

    task automatic t_ratio();
        do_reset();
        send_field(40, 2, "R4 at limit is new");
        chk("R4 new field steps phase", int'(cadence_phase), 1);
        send_field(40, 1, "R4 below limit is repeat");
        chk("R8 unlocked repeat realigns", int'(cadence_phase), 1);
        cfg_line_ratio = 4'd3;
        send_field(40, 4, "R4 ratio3 repeat");
        chk("R4 ratio3 realign", int'(cadence_phase), 1);
        send_field(40, 5, "R4 ratio3 new");
        chk("R4 ratio3 step", int'(cadence_phase), 2);
        cfg_line_ratio = 4'd4;
    endtask

    task automatic t_lock();
        do_reset();
        cad_field(1, "R6 f1");
        for (int i = 0; i < 4; i++) cad_field(0, "R6 f2-5");
        chk("R6 no lock after five fields", int'(cadence_locked), 0);
        cad_field(1, "R6 f6");
        chk("R6 lock on sixth field", int'(cadence_locked), 1);
        chk("R5 phase after lock", int'(cadence_phase), 1);
    endtask

    task automatic t_saturate();
        for (int i = 0; i < 20; i++) cad_field(m_phase == 0, "R9 agreeing run");
        chk("R9 still locked after long run", int'(cadence_locked), 1);
        for (int k = 1; k <= 11; k++) begin
            cad_field(m_phase != 0, "R7 R9 disagreeing run");
            if (k == 1) chk("R8 locked repeat does not realign", int'(cadence_phase), 2);
            if (k == 10) chk("R9 locked after ten misses", int'(cadence_locked), 1);
        end
        chk("R7 R9 unlock on eleventh miss", int'(cadence_locked), 0);
    endtask

    task automatic t_hyst();
        cad_field(m_phase == 0, "R7 hysteresis one");
        chk("R7 no relock at count 5", int'(cadence_locked), 0);
        cad_field(m_phase == 0, "R7 hysteresis two");
        chk("R6 relock at count 6", int'(cadence_locked), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_noise();
        t_strobe();
        t_ratio();
        t_lock();
        t_saturate();
        t_hyst();
        t_reset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule